// File: doc/BRIEF.md
# RS-485 Transceiver Enable Controller

This block drives the two enable pins of a half- or full-duplex RS-485 line transceiver. One pin turns the line driver on and the other turns the line receiver on. It sits beside a UART. It watches a transmitter-busy flag and a receiver-in-frame flag, and it takes configuration fields from a control register held elsewhere: a mode-on bit, a polarity bit for each pin, and a two-bit transfer mode. Two further single-bit gates let software enable the driver and the receiver separately.

Three transfer modes are provided:

- **Full duplex.** Driver and receiver may be on together.
- **Software.** Both pins follow the software gates directly.
- **Exclusive.** Hardware hands the line between transmit and receive. Both enables are never on at once, and a short guard interval follows every transmission.

In every mode, a receiver enable that is on while a frame is arriving stays on until that frame ends, even if software withdraws it. All internal logic works with active-high enables. Polarity is applied in a registered output stage, so each pin reflects the inputs one clock edge later.

Top module: `rs485_enable_ctrl`

## Requirements
- R1: While rst_n is low, after a clock edge, de_pin is 0 and re_pin is 1. These are the inactive levels for an active-high driver enable and an active-low receiver enable.
- R2: When cfg_enable is 0, both pins go to their inactive level one edge later. The inactive level is the inverse of the pin's polarity bit, and it applies whatever the other inputs are.
- R3: A polarity bit of 1 makes the pin high when its enable is asserted. A polarity bit of 0 makes it low when asserted. Pins are registered and reflect the inputs sampled at the previous edge.
- R4: cfg_mode selects the transfer mode: 0 is full duplex, 1 is software, 2 is exclusive, and 3 is reserved. In the reserved mode both enables are inactive.
- R5: In full duplex mode, the driver enable is asserted when de_en and tx_busy are both 1. The receiver enable follows re_en, and both may be asserted together.
- R6: In software mode, the driver enable follows de_en regardless of tx_busy, and the receiver enable follows re_en.
- R7: In any mode, clearing re_en while rx_in_frame is 1 and the receiver enable is asserted keeps it asserted until rx_in_frame falls. The pin goes inactive at the next edge after that. Clearing re_en when no frame is in progress deasserts it at the next edge.
- R8: In exclusive mode the driver and receiver enables are never asserted together.
- R9: In exclusive mode, a request (de_en and tx_busy both 1) with no frame arriving on an enabled receiver switches the line to transmit. On the second edge after the request, the driver pin goes active and the receiver pin goes inactive.
- R10: In exclusive mode, when the request ends, the driver pin goes inactive on the second edge. The receiver pin then stays inactive for GUARD_CYCLES further edges before it reasserts.
- R11: In exclusive mode, a request that arrives while a frame is being received through an asserted receiver enable waits until rx_in_frame falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_enable | input | 1 | Turns the RS-485 enable logic on |
| cfg_re_pol | input | 1 | Receiver pin polarity, 1 = active high |
| cfg_de_pol | input | 1 | Driver pin polarity, 1 = active high |
| cfg_mode | input | 2 | Transfer mode select |
| de_en | input | 1 | Software gate for the driver enable |
| re_en | input | 1 | Software gate for the receiver enable |
| tx_busy | input | 1 | UART transmitter has data or is shifting |
| rx_in_frame | input | 1 | UART receiver is inside a frame |
| de_pin | output | 1 | Driver enable pin, polarity applied |
| re_pin | output | 1 | Receiver enable pin, polarity applied |

## Verification
The hardest situations to reach from the ports are the exclusive-mode races. In one, a transmit request is raised while a frame is already arriving on the enabled receiver. In the other, software withdraws the receiver gate in the middle of that frame. The stimulus first asserts the receiver with a frame in progress. It then raises tx_busy, or clears re_en, while rx_in_frame is held high for several cycles, and checks that neither the driver pin nor the withheld receiver pin moves. It then drops rx_in_frame and counts the edges until the handover completes and the guard interval ends.

// File: rtl/rs485_ctl_pkg.sv
// Package: shared types for the RS-485 enable controller.
// Assumes: the mode encoding is fixed by the control register layout.
package rs485_ctl_pkg;

    // Transfer mode as decoded from the two-bit control field.
    typedef enum logic [1:0] {
        XM_DUPLEX = 2'd0,
        XM_SOFT   = 2'd1,
        XM_EXCL   = 2'd2,
        XM_RSVD   = 2'd3
    } xfer_mode_e;

    // Line ownership state for the exclusive mode.
    typedef enum logic [1:0] {
        LS_RX    = 2'd0,
        LS_TX    = 2'd1,
        LS_GUARD = 2'd2
    } line_state_e;

endpackage

// File: rtl/rs485_re_hold.sv
// Module: rs485_re_hold
// Extends the software receiver gate so that an enable already granted
// is not withdrawn while a frame is arriving.
// Assumes: re_granted is the final active-high receiver enable of the
// block, so the held state tracks what the pin actually shows.
module rs485_re_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic re_en,
    input  logic rx_in_frame,
    input  logic re_granted,
    output logic re_allow,
    output logic rx_lock
);

    logic granted_q;

    // Remember whether the receiver enable was granted last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            granted_q <= 1'b0;
        end else begin
            granted_q <= re_granted;
        end
    end

    // Receiver may be on if software asks, or if a granted frame is ongoing.
    always_comb begin
        re_allow = re_en | (granted_q & rx_in_frame);
        rx_lock  = re_allow & rx_in_frame;
    end

endmodule

// File: rtl/rs485_excl_fsm.sv
// Module: rs485_excl_fsm
// Owns the line in exclusive mode: receive, transmit, then a guard
// interval with both enables off before returning to receive.
// Assumes: GUARD_CYCLES >= 1; rx_lock marks a frame arriving on an
// enabled receiver, during which transmit may not start.
module rs485_excl_fsm
    import rs485_ctl_pkg::*;
#(
    parameter int GUARD_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic tx_req,
    input  logic rx_lock,
    input  logic re_allow,
    output logic de_x,
    output logic re_x
);

    localparam int CW = (GUARD_CYCLES < 2) ? 1 : $clog2(GUARD_CYCLES);
    localparam logic [CW-1:0] GUARD_LOAD = CW'(GUARD_CYCLES - 1);

    line_state_e   st;
    logic [CW-1:0] cnt;

    // Line ownership sequencing with guard countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= LS_RX;
            cnt <= '0;
        end else if (!active) begin
            st  <= LS_RX;
            cnt <= '0;
        end else begin
            case (st)
                LS_RX: begin
                    if (tx_req && !rx_lock) begin
                        st <= LS_TX;
                    end
                end
                LS_TX: begin
                    if (!tx_req) begin
                        st  <= LS_GUARD;
                        cnt <= GUARD_LOAD;
                    end
                end
                LS_GUARD: begin
                    if (cnt == '0) begin
                        st <= LS_RX;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: st <= LS_RX;
            endcase
        end
    end

    // Enables derived from ownership state.
    always_comb begin
        de_x = (st == LS_TX);
        re_x = (st == LS_RX) && re_allow;
    end

    // R11: a frame arriving on an enabled receiver blocks the transmit start.
    p_no_tx_during_rx_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (active && st == LS_RX && rx_lock) |=> (st != LS_TX));

    // R10: ending a transmit always passes through the guard interval.
    p_guard_after_tx_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (active && st == LS_TX && !tx_req) |=> (!active || st == LS_GUARD));

endmodule

// File: rtl/rs485_pin_stage.sv
// Module: rs485_pin_stage
// Registers the active-high enables and applies pin polarity.
// Assumes: polarity bit 1 means the pin is high when asserted.
module rs485_pin_stage #(
    parameter logic RST_DE_PIN = 1'b0,
    parameter logic RST_RE_PIN = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic de_int,
    input  logic re_int,
    input  logic de_pol,
    input  logic re_pol,
    output logic de_pin,
    output logic re_pin
);

    // Output registers with polarity folded in.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            de_pin <= RST_DE_PIN;
            re_pin <= RST_RE_PIN;
        end else begin
            de_pin <= de_pol ? de_int : ~de_int;
            re_pin <= re_pol ? re_int : ~re_int;
        end
    end

endmodule

// File: rtl/rs485_enable_ctrl.sv
// Module: rs485_enable_ctrl (top)
// Selects driver and receiver enables per transfer mode, holds the
// receiver through an arriving frame, and drives polarity-adjusted pins.
// Assumes: configuration inputs are static within a transfer.
module rs485_enable_ctrl
    import rs485_ctl_pkg::*;
#(
    parameter int   GUARD_CYCLES = 2,
    parameter logic RST_DE_PIN   = 1'b0,
    parameter logic RST_RE_PIN   = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_enable,
    input  logic       cfg_re_pol,
    input  logic       cfg_de_pol,
    input  logic [1:0] cfg_mode,
    input  logic       de_en,
    input  logic       re_en,
    input  logic       tx_busy,
    input  logic       rx_in_frame,
    output logic       de_pin,
    output logic       re_pin
);

    xfer_mode_e mode;
    logic       re_allow;
    logic       rx_lock;
    logic       de_x;
    logic       re_x;
    logic       de_int;
    logic       re_int;
    logic       excl_active;

    assign mode        = xfer_mode_e'(cfg_mode);
    assign excl_active = cfg_enable && (mode == XM_EXCL);

    rs485_re_hold i_re_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .re_en      (re_en),
        .rx_in_frame(rx_in_frame),
        .re_granted (re_int),
        .re_allow   (re_allow),
        .rx_lock    (rx_lock)
    );

    rs485_excl_fsm #(
        .GUARD_CYCLES(GUARD_CYCLES)
    ) i_excl_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (excl_active),
        .tx_req  (de_en && tx_busy),
        .rx_lock (rx_lock),
        .re_allow(re_allow),
        .de_x    (de_x),
        .re_x    (re_x)
    );

    // Mode selection of the active-high enables.
    always_comb begin
        de_int = 1'b0;
        re_int = 1'b0;
        if (cfg_enable) begin
            case (mode)
                XM_DUPLEX: begin
                    de_int = de_en && tx_busy;
                    re_int = re_allow;
                end
                XM_SOFT: begin
                    de_int = de_en;
                    re_int = re_allow;
                end
                XM_EXCL: begin
                    de_int = de_x;
                    re_int = re_x;
                end
                default: begin
                    de_int = 1'b0;
                    re_int = 1'b0;
                end
            endcase
        end
    end

    rs485_pin_stage #(
        .RST_DE_PIN(RST_DE_PIN),
        .RST_RE_PIN(RST_RE_PIN)
    ) i_pin_stage (
        .clk   (clk),
        .rst_n (rst_n),
        .de_int(de_int),
        .re_int(re_int),
        .de_pol(cfg_de_pol),
        .re_pol(cfg_re_pol),
        .de_pin(de_pin),
        .re_pin(re_pin)
    );

    // R8: exclusive mode never enables driver and receiver together.
    p_excl_mutex_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (excl_active) |-> !(de_int && re_int));

    // R7: a receiver enable granted during a frame persists to frame end.
    p_re_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (re_int && rx_in_frame && cfg_enable) |=>
        (re_int || !rx_in_frame || !cfg_enable || !$stable(cfg_mode)));

    // R2: disabled logic drives both pins to their inactive levels.
    p_disabled_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_enable) |=>
        ((de_pin != $past(cfg_de_pol)) && (re_pin != $past(cfg_re_pol))));

endmodule

// File: tb/test_rs485_enable_ctrl.sv
module test_rs485_enable_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_enable = 1'b0;
    logic       cfg_re_pol = 1'b0;
    logic       cfg_de_pol = 1'b1;
    logic [1:0] cfg_mode = 2'd0;
    logic       de_en = 1'b0;
    logic       re_en = 1'b0;
    logic       tx_busy = 1'b0;
    logic       rx_in_frame = 1'b0;
    logic       de_pin;
    logic       re_pin;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    rs485_enable_ctrl #(.GUARD_CYCLES(2)) i_rs485_enable_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable),
        .cfg_re_pol(cfg_re_pol), .cfg_de_pol(cfg_de_pol), .cfg_mode(cfg_mode),
        .de_en(de_en), .re_en(re_en), .tx_busy(tx_busy),
        .rx_in_frame(rx_in_frame), .de_pin(de_pin), .re_pin(re_pin)
    );

    // Vector: {en, re_pol, de_pol, mode[1:0], de_en, re_en, tx, rx, exp_de, exp_re}
    localparam int NV = 10;
    localparam logic [10:0] VEC [NV] = '{
        11'b0_0_1_00_1_1_1_0_0_1,   // R2 disabled, default polarity
        11'b1_0_1_00_1_1_1_0_1_0,   // R5 both asserted together
        11'b1_0_1_00_1_1_0_0_0_0,   // R5 no tx, driver off
        11'b1_1_0_00_1_1_1_0_0_1,   // R3 inverted polarities
        11'b1_1_0_00_0_0_1_0_1_0,   // R3 inactive with inverted polarity
        11'b1_0_1_01_1_0_0_0_1_1,   // R6 driver without tx_busy
        11'b1_0_1_01_0_1_1_0_0_0,   // R6 driver gated off, receiver on
        11'b1_0_1_11_1_1_1_0_0_1,   // R4 reserved mode idle
        11'b0_1_0_01_1_1_0_0_1_0,   // R2 disabled, inverted polarity
        11'b1_1_1_00_1_1_1_0_1_1    // R3 both active high
    };

    task automatic chk(input string req, input logic act_de, input logic act_re,
                       input logic exp_de, input logic exp_re);
        n_checks++;
        if (act_de !== exp_de || act_re !== exp_re) begin
            n_fail++;
            $display("FAIL %s: de_pin/re_pin actual %b/%b expected %b/%b",
                     req, act_de, act_re, exp_de, exp_re);
        end
    endtask

    // Advance n clock edges and return at the following falling edge.
    task automatic edges(input int n);
        for (int k = 0; k < n; k++) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : stim
        edges(3);
        chk("R1", de_pin, re_pin, 1'b0, 1'b1);
        rst_n = 1'b1;
        edges(1);
        chk("R2", de_pin, re_pin, 1'b0, 1'b1);

        for (int i = 0; i < NV; i++) begin
            cfg_enable  = VEC[i][10];
            cfg_re_pol  = VEC[i][9];
            cfg_de_pol  = VEC[i][8];
            cfg_mode    = VEC[i][7:6];
            de_en       = VEC[i][5];
            re_en       = VEC[i][4];
            tx_busy     = VEC[i][3];
            rx_in_frame = VEC[i][2];
            edges(1);
            chk($sformatf("R3/R4/R5/R6 vector %0d", i), de_pin, re_pin, VEC[i][1], VEC[i][0]);
        end

        // R7: receiver held through a frame in full duplex mode.
        cfg_enable = 1; cfg_re_pol = 0; cfg_de_pol = 1; cfg_mode = 2'd0;
        de_en = 0; re_en = 1; tx_busy = 0; rx_in_frame = 1;
        edges(1);
        chk("R7 granted", de_pin, re_pin, 1'b0, 1'b0);
        re_en = 0;
        edges(3);
        chk("R7 held mid-frame", de_pin, re_pin, 1'b0, 1'b0);
        rx_in_frame = 0;
        edges(1);
        chk("R7 released at frame end", de_pin, re_pin, 1'b0, 1'b1);
        rx_in_frame = 1;
        edges(2);
        chk("R7 no grant without re_en", de_pin, re_pin, 1'b0, 1'b1);
        rx_in_frame = 0;

        // R9/R10: exclusive handover and guard.
        cfg_mode = 2'd2; de_en = 1; re_en = 1;
        edges(2);
        chk("R9 idle receive", de_pin, re_pin, 1'b0, 1'b0);
        tx_busy = 1;
        edges(1);
        chk("R9 one edge after request", de_pin, re_pin, 1'b0, 1'b0);
        edges(1);
        chk("R9 transmit owned", de_pin, re_pin, 1'b1, 1'b1);
        edges(2);
        chk("R8 still transmitting", de_pin, re_pin, 1'b1, 1'b1);
        tx_busy = 0;
        edges(1);
        chk("R10 first edge after end", de_pin, re_pin, 1'b1, 1'b1);
        edges(1);
        chk("R10 driver off, guard", de_pin, re_pin, 1'b0, 1'b1);
        edges(1);
        chk("R10 guard second edge", de_pin, re_pin, 1'b0, 1'b1);
        edges(1);
        chk("R10 receiver back", de_pin, re_pin, 1'b0, 1'b0);

        // R11: request during an arriving frame waits.
        rx_in_frame = 1;
        edges(1);
        tx_busy = 1;
        edges(4);
        chk("R11 request blocked by frame", de_pin, re_pin, 1'b0, 1'b0);
        rx_in_frame = 0;
        edges(1);
        chk("R11 one edge after frame end", de_pin, re_pin, 1'b0, 1'b0);
        edges(1);
        chk("R11 transmit after frame", de_pin, re_pin, 1'b1, 1'b1);

        // R10: clearing de_en ends the transmit like tx_busy falling.
        de_en = 0;
        edges(2);
        chk("R10 de_en cleared", de_pin, re_pin, 1'b0, 1'b1);
        edges(2);
        chk("R10 guard then receive", de_pin, re_pin, 1'b0, 1'b0);

        // R2: disable from exclusive mode.
        cfg_enable = 0;
        edges(1);
        chk("R2 disable in exclusive", de_pin, re_pin, 1'b0, 1'b1);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule